// File: doc/BRIEF.md
# Reset-Triggered Memory Boot Sequencer

This block prepares the on-chip memories of a signal-processing core after reset. When the active-low reset input is released, it runs one fixed pass over a shared 10-bit address space. In that pass it streams the program boot ROM into program RAM and the parameter boot ROM into parameter RAM, and writes zero into every data memory. All memories are written in parallel, one address per clock.

The ROMs have one cycle of read latency. A single counter drives the ROM read address. A delayed copy of that counter, together with a delayed write strobe, drives the RAM write ports, so each ROM word lands at its own address. While the pass runs, a busy flag holds back host serial-port register accesses. When the last word has been written, a done flag rises and stays set until the next reset. The done flag lets the core run and opens the host gate.

If reset is asserted in the middle of the pass, the pass is abandoned. It starts again from address zero when reset is released.

Top module: `boot_seq_top`

## Requirements
- R1: On every clock edge at which rst_n_i is sampled low, the following cycle shows all write enables low, done_o low, busy_o high, rom_addr_o at 0 and rom_rd_o high.
- R2: After reset release, prog_we_o, param_we_o and every bit of dmem_we_o are high for exactly 1024 consecutive cycles. The first of these is the cycle after the first rising clock edge at which rst_n_i is sampled high.
- R3: ram_addr_o is 0 in the first write cycle and rises by one in each later write cycle, reaching 1023 in the last.
- R4: After the k-th rising edge since release, rom_addr_o equals k, saturating at 1023. rom_rd_o stays high up to and including the cycle in which address 1023 is presented. The ROMs return the word for an address one cycle after that address is presented.
- R5: In the write cycle for address a, prog_wdata_o carries program ROM word a.
- R6: In the write cycle for address a, param_wdata_o carries parameter ROM word a.
- R7: dmem_wdata_o is zero at all times, and every bit of dmem_we_o matches prog_we_o.
- R8: done_o rises in the cycle after the write to address 1023 and holds until reset. busy_o is always the complement of done_o.
- R9: host_acc_o follows host_acc_i while done_o is high and is 0 while busy_o is high.
- R10: Reset asserted during the pass stops writes in the next cycle. After release the pass restarts at address 0 and again lasts 1024 write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_n_i | input | 1 | Active-low reset, sampled synchronously; release starts the pass |
| rom_addr_o | output | 10 | Shared read address for both boot ROMs |
| rom_rd_o | output | 1 | ROM read strobe while addresses are being issued |
| prog_rom_rdata_i | input | 24 | Program ROM word, one cycle after its address |
| param_rom_rdata_i | input | 22 | Parameter ROM word, one cycle after its address |
| ram_addr_o | output | 10 | Shared write address for all RAMs |
| prog_we_o | output | 1 | Program RAM write enable |
| prog_wdata_o | output | 24 | Program RAM write data |
| param_we_o | output | 1 | Parameter RAM write enable |
| param_wdata_o | output | 22 | Parameter RAM write data |
| dmem_we_o | output | 2 | Write enable, one bit per data memory |
| dmem_wdata_o | output | 24 | Data memory write data (zero) |
| busy_o | output | 1 | Pass in progress; host locked out |
| done_o | output | 1 | Pass complete; core may run |
| host_acc_i | input | 1 | Host register access strobe from the serial port |
| host_acc_o | output | 1 | Host access strobe passed on to the registers |

## Verification
The hardest cases to reach from the ports are a reset that lands deep inside the pass and a reset that arrives after done_o is already set. Either one must discard all progress and restart at address zero, with a full 1024-cycle count. The bench pulls rst_n_i low at a chosen cycle count, once near address 300 and once after completion. It then lets the pass run through again and compares every output on every cycle against a model driven by a count of edges since release. The host strobe toggles through a pseudo-random pattern the whole time, so the lock-out is exercised both in the busy window and after it.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_DRAIN = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

    function automatic int unsigned seq_len(input int unsigned aw);
        return 32'd1 << aw;
    endfunction

    function automatic phase_e phase_next(input phase_e cur, input logic at_last);
        phase_e nxt;
        nxt = cur;
        case (cur)
            PH_FETCH: if (at_last) nxt = PH_DRAIN;
            PH_DRAIN: nxt = PH_DONE;
            PH_DONE:  nxt = PH_DONE;
            default:  nxt = PH_FETCH;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/boot_addr_gen.sv
module boot_addr_gen
    import boot_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    output logic [ADDR_W-1:0] cnt_o,
    output logic              fetch_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(seq_len(ADDR_W) - 1);

    phase_e            phase_q;
    logic [ADDR_W-1:0] cnt_q;
    logic              at_last;

    assign at_last = (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            phase_q <= PH_FETCH;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_next(phase_q, at_last);
            if (phase_q == PH_FETCH && !at_last)
                cnt_q <= cnt_q + ADDR_W'(1);
        end
    end

    assign cnt_o   = cnt_q;
    assign fetch_o = (phase_q == PH_FETCH);
    assign done_o  = (phase_q == PH_DONE);

    // R8: completion is sticky until reset
    a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        done_o |=> done_o);

    // R4: the address never moves after the pass has left the fetch phase
    a_r4_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !fetch_o |=> $stable(cnt_o));

endmodule

// File: rtl/boot_wr_stage.sv
module boot_wr_stage #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              fetch_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
    } wr_req_t;

    wr_req_t req_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            req_q <= '0;
        end else begin
            req_q.en   <= fetch_i;
            req_q.addr <= addr_i;
        end
    end

    assign we_o   = req_q.en;
    assign addr_o = req_q.addr;

    // R3: consecutive writes step the address by one
    a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (we_o && fetch_i) |=> (we_o && addr_o == $past(addr_o) + ADDR_W'(1)));

endmodule

// File: rtl/boot_host_gate.sv
module boot_host_gate (
    input  logic done_i,
    input  logic acc_i,
    output logic acc_o
);
    always_comb begin
        acc_o = 1'b0;
        if (done_i)
            acc_o = acc_i;
    end
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
    import boot_seq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned PROG_W   = 24,
    parameter int unsigned PARAM_W  = 22,
    parameter int unsigned DATA_W   = 24,
    parameter int unsigned N_DMEM   = 2
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    output logic [ADDR_W-1:0]  rom_addr_o,
    output logic               rom_rd_o,
    input  logic [PROG_W-1:0]  prog_rom_rdata_i,
    input  logic [PARAM_W-1:0] param_rom_rdata_i,
    output logic [ADDR_W-1:0]  ram_addr_o,
    output logic               prog_we_o,
    output logic [PROG_W-1:0]  prog_wdata_o,
    output logic               param_we_o,
    output logic [PARAM_W-1:0] param_wdata_o,
    output logic [N_DMEM-1:0]  dmem_we_o,
    output logic [DATA_W-1:0]  dmem_wdata_o,
    output logic               busy_o,
    output logic               done_o,
    input  logic               host_acc_i,
    output logic               host_acc_o
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(seq_len(ADDR_W) - 1);

    logic [ADDR_W-1:0] cnt;
    logic              fetch;
    logic              done;
    logic              we;
    logic [ADDR_W-1:0] waddr;

    boot_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .cnt_o   (cnt),
        .fetch_o (fetch),
        .done_o  (done)
    );

    boot_wr_stage #(.ADDR_W(ADDR_W)) u_wr (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .fetch_i (fetch),
        .addr_i  (cnt),
        .we_o    (we),
        .addr_o  (waddr)
    );

    boot_host_gate u_gate (
        .done_i (done),
        .acc_i  (host_acc_i),
        .acc_o  (host_acc_o)
    );

    assign rom_addr_o    = cnt;
    assign rom_rd_o      = fetch;
    assign ram_addr_o    = waddr;
    assign prog_we_o     = we;
    assign prog_wdata_o  = prog_rom_rdata_i;
    assign param_we_o    = we;
    assign param_wdata_o = param_rom_rdata_i;
    assign dmem_wdata_o  = '0;
    assign done_o        = done;
    assign busy_o        = ~done;

    for (genvar g = 0; g < N_DMEM; g++) begin : g_dmem
        assign dmem_we_o[g] = we;
    end

    // R1: a sampled reset leaves the block quiet in the next cycle
    a_r1_reset_quiet: assert property (@(posedge clk_i)
        !rst_n_i |=> (!prog_we_o && !param_we_o && !done_o && rom_addr_o == '0));

    // R4: while both stages run, the read address leads the write address by one
    a_r4_fetch_ahead: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (prog_we_o && rom_rd_o) |-> (rom_addr_o == ram_addr_o + ADDR_W'(1)));

    // R8: the last write is followed by completion
    a_r8_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (prog_we_o && ram_addr_o == LAST) |=> (done_o && !prog_we_o));

    // R10: every pass starts writing at address zero
    a_r10_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(prog_we_o) |-> (ram_addr_o == '0));

endmodule

// File: tb/boot_seq_top_tb_top.sv
`timescale 1ns/1ps
module boot_seq_top_tb_top;

    localparam int N_DMEM = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  rom_addr;
    logic        rom_rd;
    logic [23:0] prog_q = '0;
    logic [21:0] param_q = '0;
    logic [9:0]  ram_addr;
    logic        prog_we;
    logic [23:0] prog_wdata;
    logic        param_we;
    logic [21:0] param_wdata;
    logic [N_DMEM-1:0] dmem_we;
    logic [23:0] dmem_wdata;
    logic        busy;
    logic        done;
    logic        host_in = 1'b0;
    logic        host_out;

    int errors = 0;
    int checks = 0;
    int c = 0;          // rising edges since release (model state)
    int wcount = 0;     // write cycles in the current pass
    int cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    boot_seq_top dut_i (
        .clk_i(clk), .rst_n_i(rst_n),
        .rom_addr_o(rom_addr), .rom_rd_o(rom_rd),
        .prog_rom_rdata_i(prog_q), .param_rom_rdata_i(param_q),
        .ram_addr_o(ram_addr),
        .prog_we_o(prog_we), .prog_wdata_o(prog_wdata),
        .param_we_o(param_we), .param_wdata_o(param_wdata),
        .dmem_we_o(dmem_we), .dmem_wdata_o(dmem_wdata),
        .busy_o(busy), .done_o(done),
        .host_acc_i(host_in), .host_acc_o(host_out)
    );

    function automatic logic [23:0] prog_fn(input int a);
        return 24'((a * 937 + 74565) ^ (a << 13));
    endfunction

    function automatic logic [21:0] param_fn(input int a);
        return 22'((a * 40503) ^ 22'h2A5A5 ^ (a << 7));
    endfunction

    // ROM models: one cycle read latency
    always @(posedge clk) begin
        prog_q  <= prog_fn(int'(rom_addr));
        param_q <= param_fn(int'(rom_addr));
    end

    // Reference timeline: count of edges since release
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) c <= 0;
        else if (c < 100000) c <= c + 1;
    end

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at c=%0d", req, what, got, exp, c);
        end
    endtask

    always @(negedge clk) begin
        automatic bit e_done = (c >= 1025);
        automatic bit e_we   = (c >= 1 && c <= 1024);
        automatic int e_ra   = (c < 1023) ? c : 1023;
        if (c == 0) wcount = 0;
        if (prog_we) wcount++;
        if (c == 0) begin
            chk("R1", "reset busy", busy, 1);
            chk("R1", "reset rom_addr", rom_addr, 0);
            chk("R1", "reset rom_rd", rom_rd, 1);
        end
        chk("R2", "prog_we", prog_we, e_we);
        chk("R2", "param_we", param_we, e_we);
        for (int i = 0; i < N_DMEM; i++) chk("R7", "dmem_we", dmem_we[i], e_we);
        chk("R7", "dmem_wdata", dmem_wdata, 0);
        chk("R4", "rom_addr", rom_addr, e_ra);
        chk("R4", "rom_rd", rom_rd, (c <= 1023));
        if (e_we) begin
            chk("R3", "ram_addr", ram_addr, c - 1);
            chk("R5", "prog_wdata", prog_wdata, prog_fn(c - 1));
            chk("R6", "param_wdata", param_wdata, param_fn(c - 1));
        end
        chk("R8", "done", done, e_done);
        chk("R8", "busy", busy, !e_done);
        chk("R9", "host_acc", host_out, host_in & e_done);
        if (c == 1030) chk("R2", "write cycles per pass", wcount, 1024);
        if (c == 1 && cycles > 2000) chk("R10", "restart first addr", ram_addr, 0);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        host_in = lfsr[0];
    end

    task automatic wait_c(input int n);
        while (c < n) @(negedge clk);
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (n) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wait_c(300);        // R10: abort near address 300
        do_reset(3);
        wait_c(1100);       // full pass, done state with host traffic (R9)
        do_reset(2);        // reset from done state (R1, R8)
        wait_c(600);
        do_reset(1);
        wait_c(1100);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule